// File: doc/BRIEF.md
# Vector Lane Interleave and Narrow/Widen Unit

This block rearranges the elements of a 128-bit vector datapath without doing any arithmetic on them. It interleaves two source vectors at 8-, 16- or 32-bit element size. It narrows pairs of source vectors into one, either by truncation or with clamping. It widens half of one source into elements of twice the width. It also converts between 32-bit colour words and a 16-bit packed pixel that holds one alpha bit and three 5-bit channels.

An execution pipeline drives the opcode, the element-size select, the half select, the signedness flag and both sources. The unit computes the result in combinational logic and registers it, so the result appears one clock later. Element 0 always occupies the least significant bits of a vector. The "upper half" of a vector means bits 127:64.

Top module: `vmp_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result` becomes all zeros.
- R2: `result` after a clock edge is a function only of the inputs sampled at that edge. This gives a latency of exactly one cycle, and back-to-back operations are possible.
- R3: With `op`=000 and `hi`=0, the elements of the lower halves are interleaved. `gran` selects the element width: 00 is 8-bit, 01 is 16-bit, 10 is 32-bit. Result element 2i is element i of `src_a`, and result element 2i+1 is element i of `src_b`.
- R4: With `op`=000 and `hi`=1, the interleave takes elements from the upper halves. Result element 2i is `src_a` element N/2+i and element 2i+1 is `src_b` element N/2+i, where N is the element count.
- R5: With `op`=001 (truncating narrow), each source element is cut to its low half. `gran`=00 narrows 16-bit elements to 8-bit, and `gran`=01 narrows 32-bit elements to 16-bit. The elements of `src_a` fill the lower result half in order, and those of `src_b` fill the upper half. The value of `sgn` has no effect.
- R6: With `op`=010 and `sgn`=1, the narrowing uses the same placement as R5. Each element is read as signed and clamped to the signed range of the narrow width.
- R7: With `op`=010 and `sgn`=0, each element is read as unsigned and clamped to the maximum unsigned narrow value.
- R8: With `op`=011 (widen), `gran`=00 widens 8-bit elements to 16-bit, and `gran`=01 widens 16-bit elements to 32-bit. The elements come from the half of `src_a` selected by `hi` and are sign-extended.
- R9: With `op`=100, each 32-bit word produces a 16-bit pixel. Words from `src_a` fill pixels 0..3 and words from `src_b` fill pixels 4..7. Pixel bit 15 is word bit 24, bits 14:10 are word bits 23:19, bits 9:5 are word bits 15:11, and bits 4:0 are word bits 7:3.
- R10: With `op`=101, each of the four pixels in the half of `src_a` selected by `hi` becomes a 32-bit word. Byte 3 of the word is pixel bit 15 replicated. Bytes 2, 1 and 0 are pixel fields 14:10, 9:5 and 4:0, each zero-extended to 8 bits.
- R11: Opcodes 110 and 111, `gran`=11 with the interleave, and `gran` values 10 or 11 with narrow or widen all produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code |
| gran | input | 2 | Element size select |
| hi | input | 1 | Selects upper (1) or lower (0) source half |
| sgn | input | 1 | Signed clamping for saturating narrow |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| result | output | 128 | Registered result |

## Verification
The bench builds the unit with the default 128-bit vector width. At that width, every element size splits evenly into halves: sixteen bytes, eight halfwords and four words. The independent model in the bench therefore reaches every interleave position, both narrowing widths at their clamp edges, and all four pixel lanes of each half. The bench compares the model's output on every clock, for directed boundary values and for a long run of random operands covering every opcode and select.

// File: rtl/vmp_pkg.sv
`timescale 1ns/1ps
package vmp_pkg;
    typedef enum logic [2:0] {
        OP_MERGE      = 3'd0,
        OP_PACK_MOD   = 3'd1,
        OP_PACK_SAT   = 3'd2,
        OP_UNPACK     = 3'd3,
        OP_PIX_PACK   = 3'd4,
        OP_PIX_UNPACK = 3'd5,
        OP_RSVD6      = 3'd6,
        OP_RSVD7      = 3'd7
    } vmp_op_e;

    typedef enum logic [1:0] {
        G_BYTE = 2'd0,
        G_HALF = 2'd1,
        G_WORD = 2'd2,
        G_RSVD = 2'd3
    } vmp_gran_e;

    localparam int unsigned MERGE_SIZES = 3;
    localparam int unsigned NARROW_SIZES = 2;
    localparam int unsigned BASE_EW = 8;
endpackage

// File: rtl/vmp_merge.sv
`timescale 1ns/1ps
module vmp_merge #(
    parameter int unsigned VW = 128
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    input  logic [1:0]    gran,
    input  logic          hi,
    output logic [VW-1:0] res
);
    import vmp_pkg::*;

    logic [VW-1:0] lo_v [MERGE_SIZES];
    logic [VW-1:0] hi_v [MERGE_SIZES];

    for (genvar g = 0; g < MERGE_SIZES; g++) begin : g_size
        localparam int unsigned EW = BASE_EW << g;
        localparam int unsigned NE = VW / EW;
        localparam int unsigned HALF = NE / 2;
        for (genvar i = 0; i < HALF; i++) begin : g_el
            assign lo_v[g][(2*i)*EW   +: EW] = a[i*EW +: EW];
            assign lo_v[g][(2*i+1)*EW +: EW] = b[i*EW +: EW];
            assign hi_v[g][(2*i)*EW   +: EW] = a[(HALF+i)*EW +: EW];
            assign hi_v[g][(2*i+1)*EW +: EW] = b[(HALF+i)*EW +: EW];
        end
    end

    always_comb begin
        unique case (vmp_gran_e'(gran))
            G_BYTE:  res = hi ? hi_v[0] : lo_v[0];
            G_HALF:  res = hi ? hi_v[1] : lo_v[1];
            G_WORD:  res = hi ? hi_v[2] : lo_v[2];
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/vmp_narrow.sv
`timescale 1ns/1ps
module vmp_narrow #(
    parameter int unsigned SW = 16
) (
    input  logic [SW-1:0]   din,
    input  logic            sat,
    input  logic            sgn,
    output logic [SW/2-1:0] dout
);
    localparam int unsigned DW = SW / 2;

    logic          s_fit;
    logic          u_fit;
    logic [DW-1:0] s_lim;

    always_comb begin
        s_fit = (din[SW-1:DW-1] == '0) || (din[SW-1:DW-1] == '1);
        u_fit = (din[SW-1:DW] == '0);
        s_lim = din[SW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        if (!sat)
            dout = din[DW-1:0];
        else if (sgn)
            dout = s_fit ? din[DW-1:0] : s_lim;
        else
            dout = u_fit ? din[DW-1:0] : '1;
    end
endmodule

// File: rtl/vmp_pack.sv
`timescale 1ns/1ps
module vmp_pack #(
    parameter int unsigned VW = 128
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    input  logic [1:0]    gran,
    input  logic          sat,
    input  logic          sgn,
    output logic [VW-1:0] res
);
    import vmp_pkg::*;

    logic [2*VW-1:0] ab;
    logic [VW-1:0]   nar_v [NARROW_SIZES];

    assign ab = {b, a};

    for (genvar g = 0; g < NARROW_SIZES; g++) begin : g_size
        localparam int unsigned SW = (2 * BASE_EW) << g;
        localparam int unsigned DW = SW / 2;
        localparam int unsigned NT = (2 * VW) / SW;
        for (genvar i = 0; i < NT; i++) begin : g_el
            vmp_narrow #(.SW(SW)) u_nar (
                .din  (ab[i*SW +: SW]),
                .sat  (sat),
                .sgn  (sgn),
                .dout (nar_v[g][i*DW +: DW])
            );
        end
    end

    always_comb begin
        unique case (vmp_gran_e'(gran))
            G_BYTE:  res = nar_v[0];
            G_HALF:  res = nar_v[1];
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/vmp_unpack.sv
`timescale 1ns/1ps
module vmp_unpack #(
    parameter int unsigned VW = 128
) (
    input  logic [VW-1:0] a,
    input  logic [1:0]    gran,
    input  logic          hi,
    output logic [VW-1:0] res
);
    import vmp_pkg::*;

    localparam int unsigned HW = VW / 2;

    logic [HW-1:0] half;
    logic [VW-1:0] wid_v [NARROW_SIZES];

    assign half = hi ? a[VW-1:HW] : a[HW-1:0];

    for (genvar g = 0; g < NARROW_SIZES; g++) begin : g_size
        localparam int unsigned SW = BASE_EW << g;
        localparam int unsigned DW = 2 * SW;
        localparam int unsigned NE = VW / DW;
        for (genvar i = 0; i < NE; i++) begin : g_el
            assign wid_v[g][i*DW +: DW] = {{SW{half[i*SW+SW-1]}}, half[i*SW +: SW]};
        end
    end

    always_comb begin
        unique case (vmp_gran_e'(gran))
            G_BYTE:  res = wid_v[0];
            G_HALF:  res = wid_v[1];
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/vmp_pixel.sv
`timescale 1ns/1ps
module vmp_pixel #(
    parameter int unsigned VW = 128
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    input  logic          hi,
    output logic [VW-1:0] pk,
    output logic [VW-1:0] up
);
    localparam int unsigned NW = VW / 32;
    localparam int unsigned HW = VW / 2;

    logic [2*VW-1:0] ab;
    logic [HW-1:0]   half;

    assign ab   = {b, a};
    assign half = hi ? a[VW-1:HW] : a[HW-1:0];

    for (genvar i = 0; i < 2*NW; i++) begin : g_pk
        assign pk[i*16 +: 16] = {ab[i*32+24], ab[i*32+19 +: 5],
                                 ab[i*32+11 +: 5], ab[i*32+3 +: 5]};
    end

    for (genvar i = 0; i < NW; i++) begin : g_up
        assign up[i*32 +: 32] = {{8{half[i*16+15]}},
                                 3'b000, half[i*16+10 +: 5],
                                 3'b000, half[i*16+5 +: 5],
                                 3'b000, half[i*16 +: 5]};
    end
endmodule

// File: rtl/vmp_unit.sv
`timescale 1ns/1ps
module vmp_unit #(
    parameter int unsigned VW = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op,
    input  logic [1:0]    gran,
    input  logic          hi,
    input  logic          sgn,
    input  logic [127:0]  src_a,
    input  logic [127:0]  src_b,
    output logic [127:0]  result
);
    import vmp_pkg::*;

    vmp_op_e     op_e;
    logic [VW-1:0] merge_r, pack_r, unpk_r, pixp_r, pixu_r;
    logic [VW-1:0] nxt;

    assign op_e = vmp_op_e'(op);

    vmp_merge #(.VW(VW)) u_merge (
        .a(src_a), .b(src_b), .gran(gran), .hi(hi), .res(merge_r)
    );

    vmp_pack #(.VW(VW)) u_pack (
        .a(src_a), .b(src_b), .gran(gran),
        .sat(op_e == OP_PACK_SAT), .sgn(sgn), .res(pack_r)
    );

    vmp_unpack #(.VW(VW)) u_unpack (
        .a(src_a), .gran(gran), .hi(hi), .res(unpk_r)
    );

    vmp_pixel #(.VW(VW)) u_pixel (
        .a(src_a), .b(src_b), .hi(hi), .pk(pixp_r), .up(pixu_r)
    );

    always_comb begin
        unique case (op_e)
            OP_MERGE:                nxt = merge_r;
            OP_PACK_MOD, OP_PACK_SAT: nxt = pack_r;
            OP_UNPACK:               nxt = unpk_r;
            OP_PIX_PACK:             nxt = pixp_r;
            OP_PIX_UNPACK:           nxt = pixu_r;
            default:                 nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) result <= '0;
        else     result <= nxt;
    end
endmodule

// File: rtl/vmp_unit_chk.sv
`timescale 1ns/1ps
module vmp_unit_chk #(
    parameter int unsigned VW = 128
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    op,
    input logic [1:0]    gran,
    input logic          hi,
    input logic          sgn,
    input logic [127:0]  src_a,
    input logic [127:0]  src_b,
    input logic [127:0]  result
);
    logic live;

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (live && $stable(op) && $stable(gran) && $stable(hi) && $stable(sgn)
         && $stable(src_a) && $stable(src_b)) |=> $stable(result));

    p_merge_lo_byte_r3: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd0 && gran == 2'd0 && !hi) |=>
        (result[15:0] == {$past(src_b[7:0]), $past(src_a[7:0])}));

    p_merge_hi_word_r4: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd0 && gran == 2'd2 && hi) |=>
        (result[63:0] == {$past(src_b[VW/2 +: 32]), $past(src_a[VW/2 +: 32])}));

    p_pack_trunc_r5: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd1 && gran == 2'd0) |=>
        (result[7:0] == $past(src_a[7:0]) && result[VW/2 +: 8] == $past(src_b[7:0])));

    p_sat_signed_r6: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd2 && gran == 2'd0 && sgn && !src_a[15] && src_a[14:7] != 8'h00) |=>
        (result[7:0] == 8'h7F));

    p_sat_unsigned_r7: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd2 && gran == 2'd0 && !sgn && src_a[15:8] != 8'h00) |=>
        (result[7:0] == 8'hFF));

    p_widen_r8: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd3 && gran == 2'd0 && !hi) |=>
        (result[15:0] == {{8{$past(src_a[7])}}, $past(src_a[7:0])}));

    p_pixpack_r9: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd4) |=>
        (result[15:0] == {$past(src_a[24]), $past(src_a[23:19]),
                          $past(src_a[15:11]), $past(src_a[7:3])}));

    p_pixunpack_r10: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd5 && !hi) |=>
        (result[31:0] == {{8{$past(src_a[15])}}, 3'b000, $past(src_a[14:10]),
                          3'b000, $past(src_a[9:5]), 3'b000, $past(src_a[4:0])}));

    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (op[2:1] == 2'b11) |=> (result == '0));
endmodule

bind vmp_unit vmp_unit_chk #(.VW(VW)) u_chk (
    .clk(clk), .rst(rst), .op(op), .gran(gran), .hi(hi), .sgn(sgn),
    .src_a(src_a), .src_b(src_b), .result(result)
);

// File: tb/vmp_unit_bench.sv
`timescale 1ns/1ps
module vmp_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   op = '0;
    logic [1:0]   gran = '0;
    logic         hi = 1'b0;
    logic         sgn = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] result;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vmp_unit u_vmp_unit (
        .clk(clk), .rst(rst), .op(op), .gran(gran), .hi(hi), .sgn(sgn),
        .src_a(src_a), .src_b(src_b), .result(result)
    );

    function automatic longint get_el(logic [127:0] v, int idx, int w);
        logic [127:0] t;
        t = v >> (idx * w);
        return longint'(t[63:0]) & ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [127:0] put_el(logic [127:0] r, int idx, int w, longint val);
        logic [127:0] t;
        t = 128'(val & ((64'd1 << w) - 64'd1));
        return r | (t << (idx * w));
    endfunction

    function automatic logic [127:0] model(int o, int g, bit h, bit s,
                                           logic [127:0] a, logic [127:0] b);
        logic [127:0] r;
        r = '0;
        if (o == 0 && g < 3) begin
            int ew = 8 << g;
            int n = 128 / ew;
            int base = h ? n / 2 : 0;
            for (int i = 0; i < n / 2; i++) begin
                r = put_el(r, 2*i, ew, get_el(a, base + i, ew));
                r = put_el(r, 2*i + 1, ew, get_el(b, base + i, ew));
            end
        end else if ((o == 1 || o == 2) && g < 2) begin
            int sw = 16 << g;
            int dw = sw / 2;
            int n = 128 / sw;
            for (int i = 0; i < 2*n; i++) begin
                longint v = (i < n) ? get_el(a, i, sw) : get_el(b, i - n, sw);
                if (o == 2) begin
                    if (s) begin
                        longint sv = (v >= (64'sd1 <<< (sw-1))) ? v - (64'sd1 <<< sw) : v;
                        longint mx = (64'sd1 <<< (dw-1)) - 1;
                        longint mn = -(64'sd1 <<< (dw-1));
                        if (sv > mx) sv = mx;
                        if (sv < mn) sv = mn;
                        v = sv;
                    end else if (v > (64'sd1 <<< dw) - 1) begin
                        v = (64'sd1 <<< dw) - 1;
                    end
                end
                r = put_el(r, i, dw, v);
            end
        end else if (o == 3 && g < 2) begin
            int sw = 8 << g;
            int n = 128 / (2 * sw);
            for (int i = 0; i < n; i++) begin
                longint v = get_el(a, (h ? n : 0) + i, sw);
                if ((v >> (sw - 1)) & 1) v = v | (((64'sd1 <<< sw) - 1) <<< sw);
                r = put_el(r, i, 2 * sw, v);
            end
        end else if (o == 4) begin
            for (int i = 0; i < 8; i++) begin
                longint w = (i < 4) ? get_el(a, i, 32) : get_el(b, i - 4, 32);
                longint px = (((w >> 24) & 1) << 15) | (((w >> 19) & 31) << 10)
                           | (((w >> 11) & 31) << 5) | ((w >> 3) & 31);
                r = put_el(r, i, 16, px);
            end
        end else if (o == 5) begin
            for (int i = 0; i < 4; i++) begin
                longint p = get_el(a, (h ? 4 : 0) + i, 16);
                longint w = ((((p >> 15) & 1) != 0 ? 64'sd255 : 64'sd0) << 24)
                          | (((p >> 10) & 31) << 16) | (((p >> 5) & 31) << 8) | (p & 31);
                r = put_el(r, i, 32, w);
            end
        end
        return r;
    endfunction

    function automatic string tag_of(int o, int g, bit h, bit s);
        if (o == 0) return (g == 3) ? "R11" : (h ? "R4" : "R3");
        if (o == 1) return (g > 1) ? "R11" : "R5";
        if (o == 2) return (g > 1) ? "R11" : (s ? "R6" : "R7");
        if (o == 3) return (g > 1) ? "R11" : "R8";
        if (o == 4) return "R9";
        if (o == 5) return "R10";
        return "R11";
    endfunction

    task automatic check(string tag, logic [127:0] exp);
        n_chk++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, result, exp);
        end
    endtask

    // drive at a falling edge, compare at the next falling edge (one register)
    task automatic run(int o, int g, bit h, bit s, logic [127:0] a, logic [127:0] b,
                       string force_tag = "");
        logic [127:0] exp;
        op = 3'(o); gran = 2'(g); hi = h; sgn = s; src_a = a; src_b = b;
        exp = model(o, g, h, s, a, b);
        @(negedge clk);
        check((force_tag != "") ? force_tag : tag_of(o, g, h, s), exp);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [127:0] ia, ib;
        ia = 128'h1F1E1D1C_1B1A1918_17161514_13121110;
        ib = 128'h2F2E2D2C_2B2A2928_27262524_23222120;

        // R1: reset state
        op = 3'd0; src_a = ia; src_b = ib;
        repeat (2) @(negedge clk);
        check("R1", '0);
        rst = 1'b0;
        @(negedge clk);

        // R3 / R4: interleave at each size and half
        for (int g = 0; g < 3; g++) begin
            run(0, g, 1'b0, 1'b0, ia, ib);
            run(0, g, 1'b1, 1'b0, ia, ib);
        end

        // R5: truncating narrow, sgn has no effect
        run(1, 0, 1'b0, 1'b0, ia, ib);
        run(1, 0, 1'b0, 1'b1, ia, ib);
        run(1, 1, 1'b0, 1'b1, ia, ib);

        // R6: signed clamp boundaries
        run(2, 0, 1'b0, 1'b1, 128'h8000_7FFF_FF80_007F_0080_FF7F_0000_FFFF,
                              128'h7F80_8001_0100_FE00_FFFF_0001_4000_C000);
        run(2, 1, 1'b0, 1'b1, 128'h80000000_7FFFFFFF_FFFF8000_00007FFF,
                              128'h00008000_FFFF7FFF_12345678_F0000000);
        // R7: unsigned clamp boundaries
        run(2, 0, 1'b0, 1'b0, 128'h00FF_0100_FFFF_0000_00FE_8000_7FFF_0001, ib);
        run(2, 1, 1'b0, 1'b0, 128'h0000FFFF_00010000_FFFFFFFF_00000000, ia);

        // R8: widen from each half
        for (int g = 0; g < 2; g++) begin
            run(3, g, 1'b0, 1'b0, 128'h80FF7F01_00FE8180_01020304_F0E0D0C0, ib);
            run(3, g, 1'b1, 1'b0, 128'h80FF7F01_00FE8180_01020304_F0E0D0C0, ib);
        end

        // R9 / R10: pixel conversions
        run(4, 0, 1'b0, 1'b0, 128'hFFFFFFFF_01F8F8F8_00070707_FE000000,
                              128'h81234567_7EABCDEF_00000000_01000000);
        run(5, 0, 1'b0, 1'b0, 128'h0000FFFF_8000_7FFF_FFFF_0001_8421_7C1F, ib);
        run(5, 0, 1'b1, 1'b0, 128'h8000_7FFF_FFFF_0001_0000FFFF_12345678, ib);

        // R11: reserved encodings
        run(6, 0, 1'b0, 1'b0, ia, ib);
        run(7, 1, 1'b1, 1'b1, ia, ib);
        run(0, 3, 1'b0, 1'b0, ia, ib);
        run(1, 2, 1'b0, 1'b0, ia, ib);
        run(3, 3, 1'b1, 1'b0, ia, ib);

        // R2: back-to-back distinct operations each seen one cycle later
        run(0, 0, 1'b0, 1'b0, ia, ib, "R2");
        run(4, 0, 1'b0, 1'b0, ib, ia, "R2");
        run(3, 1, 1'b1, 1'b0, ib, ia, "R2");

        // R1: reset in mid-stream
        op = 3'd4; src_a = ia; src_b = ib; rst = 1'b1;
        @(negedge clk);
        check("R1", '0);
        rst = 1'b0;

        // random operands over every select
        for (int k = 0; k < 600; k++) begin
            run(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                1'($urandom), 1'($urandom), rnd128(), rnd128());
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule